// File: doc/BRIEF.md
# Serial Front-Panel LED Driver

This block turns a parallel picture of a front panel into the serial waveform that a daisy-chained serial-in, parallel-out shift-register chain expects. The panel carries thirty numbered channel LEDs and three named status LEDs (System, D-Channel, Sync). The host logic presents a 30-bit channel vector, a 3-bit status vector and a one-cycle update request. The block then sends the 33-bit frame out on one data line under a slow shift clock, pulses a storage clock to move the whole pattern into the chain's output registers at once, and from then on drives the active-low output enable so the LEDs light.

Each half of the shift clock, and the storage pulse, lasts a programmable number of system clocks. The inputs are copied into a holding register when a frame starts, so they may change freely while a frame is going out. A request that arrives while a frame is busy is remembered and served with the newest inputs as soon as the current frame ends. The chain is forty stages long, so the seven stages furthest from the driver carry no LED.

Top module: `panel_led_serializer`

## Requirements
- R1: After reset, ser_clk, store_clk, ser_data and busy are low and out_en_n is high.
- R2: A frame is 33 bits sent in this order: chan_leds[0] (channel LED 1) first through chan_leds[29] (channel LED 30), then status_leds[0] (System), status_leds[1] (D-Channel) and status_leds[2] (Sync) last; a 1 means the LED is lit.
- R3: Each low and each high phase of ser_clk lasts PHASE_CLKS system clocks, and ser_data does not change while ser_clk is high.
- R4: Each frame produces exactly 33 rising edges of ser_clk, followed by one store_clk pulse of PHASE_CLKS clocks during which ser_clk stays low.
- R5: out_en_n stays high from reset until the end of the first store_clk pulse and stays low from then on.
- R6: busy rises one clock after the request is taken and stays high for exactly (2*33+1)*PHASE_CLKS clocks, covering every shift phase and the store pulse.
- R7: Requests made while busy are remembered and served by exactly one further frame that starts one clock after busy falls and uses the inputs present at its start.
- R8: Changes of chan_leds or status_leds during a frame do not alter the pattern stored by that frame.
- R9: Without a request, no ser_clk or store_clk edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_leds | input | 30 | Channel LED states, bit 0 is channel LED 1 |
| status_leds | input | 3 | Bit 0 System, bit 1 D-Channel, bit 2 Sync |
| update_req | input | 1 | One-cycle request to send a new frame |
| ser_data | output | 1 | Serial data to the chain |
| ser_clk | output | 1 | Shift clock to the chain |
| store_clk | output | 1 | Storage clock, moves the pattern to the outputs |
| out_en_n | output | 1 | Active-low output enable of the chain |
| busy | output | 1 | High while a frame is being sent or stored |

## Verification
The bench builds the block with PHASE_CLKS set to 3, an odd value that makes an off-by-one in the phase counter visible in every phase length and in the total busy window, while keeping a frame at about two hundred clocks. It models the 40-stage chain itself, shifting on each ser_clk rise and copying on each store_clk rise, so frame order is judged from what the chain would display. The default channel and status counts are kept so the full 33-bit frame and its bit counter limit are exercised.

// File: rtl/led_panel_pkg.sv
package led_panel_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_HIGH  = 2'd2,
    ST_STORE = 2'd3
  } panel_state_t;

  // Number of bits in one frame.
  function automatic int frame_width(input int chans, input int stats);
    return chans + stats;
  endfunction

  // Clocks that busy stays high for one frame.
  function automatic int frame_cycles(input int nbits, input int phase);
    return (2 * nbits + 1) * phase;
  endfunction

endpackage

// File: rtl/led_phase_timer.sv
module led_phase_timer #(
  parameter int PHASE_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(PHASE_CLKS + 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(PHASE_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R3: the counter never passes the phase limit
  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(PHASE_CLKS - 1));

endmodule

// File: rtl/led_frame_holder.sv
module led_frame_holder #(
  parameter int CHAN_COUNT   = 30,
  parameter int STATUS_COUNT = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    shift,
  input  logic [CHAN_COUNT-1:0]   chan_in,
  input  logic [STATUS_COUNT-1:0] status_in,
  output logic                    head_bit
);
  localparam int FRAME_BITS = led_panel_pkg::frame_width(CHAN_COUNT, STATUS_COUNT);

  logic [FRAME_BITS-1:0] packed_frame;
  logic [FRAME_BITS-1:0] hold_q;

  // Bit 0 leaves first: channels in rising order, then the status LEDs.
  for (genvar i = 0; i < CHAN_COUNT; i++) begin : g_chan
    assign packed_frame[i] = chan_in[i];
  end
  for (genvar j = 0; j < STATUS_COUNT; j++) begin : g_stat
    assign packed_frame[CHAN_COUNT + j] = status_in[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= '0;
    else if (load)  hold_q <= packed_frame;
    else if (shift) hold_q <= {1'b0, hold_q[FRAME_BITS-1:1]};
  end

  assign head_bit = hold_q[0];

  // R8: load and shift never coincide
  assert_load_shift_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));

endmodule

// File: rtl/led_seq_ctrl.sv
module led_seq_ctrl
  import led_panel_pkg::*;
#(
  parameter int FRAME_BITS = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic         tick,
  output panel_state_t state,
  output logic         frame_start,
  output logic         bit_done,
  output logic         store_done,
  output logic         oe_n
);
  localparam int BW = $clog2(FRAME_BITS + 1);

  panel_state_t  state_q;
  logic [BW-1:0] bit_cnt;
  logic          pend_q;
  logic          last_bit;

  assign state       = state_q;
  assign frame_start = (state_q == ST_IDLE) && (req || pend_q);
  assign bit_done    = (state_q == ST_HIGH) && tick;
  assign last_bit    = bit_cnt == BW'(FRAME_BITS - 1);
  assign store_done  = (state_q == ST_STORE) && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_cnt <= '0;
      pend_q  <= 1'b0;
      oe_n    <= 1'b1;
    end else begin
      if (frame_start)                     pend_q <= 1'b0;
      else if (state_q != ST_IDLE && req)  pend_q <= 1'b1;

      case (state_q)
        ST_IDLE: if (frame_start) begin
          state_q <= ST_SETUP;
          bit_cnt <= '0;
        end
        ST_SETUP: if (tick) state_q <= ST_HIGH;
        ST_HIGH: if (tick) begin
          bit_cnt <= bit_cnt + 1'b1;
          state_q <= last_bit ? ST_STORE : ST_SETUP;
        end
        ST_STORE: if (tick) begin
          state_q <= ST_IDLE;
          oe_n    <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4: the store phase is entered only after the full frame has gone out
  assert_store_after_full_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STORE) |-> (bit_cnt == BW'(FRAME_BITS)));

  // R7: a remembered request is served on the next clock once idle
  assert_pending_served_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && pend_q) |=> (state_q == ST_SETUP));

  // R5: enable only drops at the end of a store phase
  assert_oe_after_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> $past(store_done));

endmodule

// File: rtl/panel_led_serializer.sv
module panel_led_serializer
  import led_panel_pkg::*;
#(
  parameter int CHAN_COUNT   = 30,
  parameter int STATUS_COUNT = 3,
  parameter int PHASE_CLKS   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CHAN_COUNT-1:0]   chan_leds,
  input  logic [STATUS_COUNT-1:0] status_leds,
  input  logic                    update_req,
  output logic                    ser_data,
  output logic                    ser_clk,
  output logic                    store_clk,
  output logic                    out_en_n,
  output logic                    busy
);
  localparam int FRAME_BITS = frame_width(CHAN_COUNT, STATUS_COUNT);

  panel_state_t state;
  logic         tick;
  logic         frame_start;
  logic         bit_done;
  logic         store_done;
  logic         head_bit;
  logic         shifting;

  led_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state != ST_IDLE),
    .tick  (tick)
  );

  led_seq_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (update_req),
    .tick        (tick),
    .state       (state),
    .frame_start (frame_start),
    .bit_done    (bit_done),
    .store_done  (store_done),
    .oe_n        (out_en_n)
  );

  led_frame_holder #(
    .CHAN_COUNT   (CHAN_COUNT),
    .STATUS_COUNT (STATUS_COUNT)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (frame_start),
    .shift     (bit_done),
    .chan_in   (chan_leds),
    .status_in (status_leds),
    .head_bit  (head_bit)
  );

  assign shifting  = (state == ST_SETUP) || (state == ST_HIGH);
  assign ser_data  = shifting && head_bit;
  assign ser_clk   = (state == ST_HIGH);
  assign store_clk = (state == ST_STORE);
  assign busy      = (state != ST_IDLE);

  // R4: shift and storage clocks are never high together
  assert_clk_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_clk && store_clk));

  // R5: once enabled, the panel stays enabled
  assert_oe_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_n |=> !out_en_n);

  // R3: data holds while the shift clock is high
  assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  // R6: every clock pulse falls inside the busy window
  assert_busy_cover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk || store_clk) |-> busy);

endmodule

// File: tb/panel_led_serializer_bench.sv
`timescale 1ns/1ps
module panel_led_serializer_bench;
  localparam int P = 3;
  localparam int NB = 33;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] chan = '0;
  logic [2:0]  stat = '0;
  logic        req = 1'b0;
  logic        sdata, sclk, stclk, oe_n, busy;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  panel_led_serializer #(.PHASE_CLKS(P)) u_panel_led_serializer (
    .clk(clk), .rst_n(rst_n), .chan_leds(chan), .status_leds(stat),
    .update_req(req), .ser_data(sdata), .ser_clk(sclk), .store_clk(stclk),
    .out_en_n(oe_n), .busy(busy)
  );

  // Chain model and per-frame statistics
  logic [39:0] chain = '0;
  logic [39:0] shown = '0;
  logic prev_sclk = 0, prev_stclk = 0, prev_busy = 0, prev_sdata = 0;
  int run_len = 0, rises = 0, stores = 0, st_len = 0, busy_len = 0;
  int phase_bad = 0, data_bad = 0, overlap = 0, oe_in_store = 0;

  always @(negedge clk) begin
    if (busy) begin
      busy_len++;
      if (prev_busy && sclk == prev_sclk) run_len++;
      else begin
        if (prev_busy && run_len != P) phase_bad++;
        run_len = 1;
      end
    end
    if (sclk && prev_sclk && sdata != prev_sdata) data_bad++;
    if (sclk && !prev_sclk) begin chain = {chain[38:0], sdata}; rises++; end
    if (stclk && !prev_stclk) begin shown = chain; stores++; oe_in_store = oe_n; end
    if (stclk) st_len++;
    if (stclk && sclk) overlap++;
    prev_sclk = sclk; prev_stclk = stclk; prev_busy = busy; prev_sdata = sdata;
  end

  task automatic check(input bit ok, input string req_tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  // Chain contents after 33 shifts: the first bit sent sits deepest.
  function automatic logic [32:0] expect_chain(input logic [29:0] c, input logic [2:0] s);
    logic [32:0] r;
    for (int p = 0; p < NB; p++) begin
      logic b;
      if (p < 30) b = c[p];
      else b = s[p-30];
      r[32-p] = b;
    end
    return r;
  endfunction

  task automatic clear_stats();
    rises = 0; stores = 0; st_len = 0; busy_len = 0;
    phase_bad = 0; data_bad = 0; overlap = 0;
  endtask

  task automatic pulse_req();
    @(posedge clk); #1 req = 1'b1;
    @(posedge clk); #1 req = 1'b0;
  endtask

  task automatic wait_frame();
    do @(negedge clk); while (!busy);
    do @(negedge clk); while (busy);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!sclk && !stclk && !sdata && !busy, "R1", "idle outputs", {sclk,stclk,sdata,busy}, 0);
    check(oe_n == 1'b1, "R1", "oe_n after reset", oe_n, 1);
  endtask

  task automatic t_no_request();
    clear_stats();
    chan = 30'h155; stat = 3'b101;
    repeat (40) @(negedge clk);
    check(rises == 0 && stores == 0, "R9", "edges without request", rises + stores, 0);
    check(oe_n == 1'b1, "R5", "oe_n before first store", oe_n, 1);
  endtask

  task automatic t_frame(input logic [29:0] c, input logic [2:0] s, input bit first);
    @(posedge clk); #1 chan = c; stat = s;
    clear_stats();
    pulse_req();
    wait_frame();
    check(shown[32:0] == expect_chain(c, s), "R2", "stored pattern", shown[32:0], expect_chain(c, s));
    check(rises == NB, "R4", "shift rises", rises, NB);
    check(stores == 1 && st_len == P, "R4", "store pulse", {stores, st_len}, {1, P});
    check(overlap == 0, "R4", "clock overlap", overlap, 0);
    check(phase_bad == 0 && data_bad == 0, "R3", "phase timing", {phase_bad, data_bad}, 0);
    check(busy_len == (2*NB+1)*P, "R6", "busy length", busy_len, (2*NB+1)*P);
    check(oe_in_store == first, "R5", "oe_n during store", oe_in_store, first);
    check(oe_n == 1'b0, "R5", "oe_n after store", oe_n, 0);
  endtask

  task automatic t_input_change();
    logic [29:0] a = 30'h0F0F0F0F;
    logic [2:0]  as = 3'b011;
    @(posedge clk); #1 chan = a; stat = as;
    clear_stats();
    pulse_req();
    repeat (40) @(posedge clk);
    #1 chan = ~a; stat = ~as;
    wait_frame();
    repeat (20) @(negedge clk);
    check(shown[32:0] == expect_chain(a, as), "R8", "pattern unaffected", shown[32:0], expect_chain(a, as));
    check(stores == 1, "R8", "no extra frame", stores, 1);
  endtask

  task automatic t_pending();
    logic [29:0] a = 30'h12345678;
    logic [29:0] b = 30'h2DCBA987;
    int gap;
    @(posedge clk); #1 chan = a; stat = 3'b110;
    clear_stats();
    pulse_req();
    repeat (30) @(posedge clk);
    #1 chan = b; stat = 3'b001;
    pulse_req();
    repeat (20) @(posedge clk);
    pulse_req();
    do @(negedge clk); while (busy);
    check(shown[32:0] == expect_chain(a, 3'b110), "R7", "first frame", shown[32:0], expect_chain(a, 3'b110));
    gap = 0;
    while (!busy && gap < 10) begin @(negedge clk); gap++; end
    check(gap == 1, "R7", "restart delay", gap, 1);
    do @(negedge clk); while (busy);
    check(shown[32:0] == expect_chain(b, 3'b001), "R7", "second frame newest inputs", shown[32:0], expect_chain(b, 3'b001));
    repeat (30) @(negedge clk);
    check(stores == 2, "R7", "requests collapsed", stores, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_no_request();
    t_frame(30'h2AAAAAAA, 3'b001, 1'b1);
    t_frame(30'h00000001, 3'b100, 1'b0);
    t_frame(30'h3FFFFFFF, 3'b010, 1'b0);
    t_input_change();
    t_pending();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule